// File: doc/BRIEF.md
# Latch-or-Register Bus Driver

The block carries a parameterised data word from an input bus to an output bus through one storage stage per bit. A mode input sets how that stage behaves. While the pass-through control is high the stage copies the input word on every system clock, so the output follows the input. While it is low the stage loads the input only on a rising transition of a separate capture strobe, and otherwise keeps its word. A single active-low enable decides whether the output bus is driven. When the bus is not driven it floats, and the storage keeps updating behind it.

All logic runs on one system clock. The capture strobe and the controls are sampled as levels, and the strobe's rising transition is found by comparing each sample with the one before it. The stored word is brought out as a plain data bus together with a registered drive flag, for use inside a device. A tri-state copy of the bus is also provided for use at a pin. Every output changes one system clock after the inputs that cause the change are sampled.

Top module: `lat_reg_driver`

## Requirements
- R1: While `rst` is high at a clock edge, the stored word is cleared to zero and the drive flag is cleared, so `y_pad` floats in every bit.
- R2: If `oe_n` is 1 at a clock edge, then from that edge on `y_oe` is 0 and every bit of `y_pad` is high impedance, whatever `le`, `cap_clk` and `a_in` are.
- R3: If `oe_n` is 0 at a clock edge, then from that edge on `y_oe` is 1 and `y_pad` equals `y_data`.
- R4: If `le` is 1 at a clock edge, `y_data` takes the `a_in` sampled at that edge, so the output follows the input one clock later.
- R5: If `le` is 0, `cap_clk` is 1 at a clock edge and `cap_clk` was 0 at the edge before, `y_data` takes the `a_in` sampled at that edge.
- R6: If `le` is 0 and `cap_clk` has the same level as at the previous edge (steady high or steady low), `y_data` does not change, even when `a_in` changes.
- R7: When `le` goes from 1 to 0, the word kept is the last one passed in pass-through mode, whether `cap_clk` is high or low at that moment.
- R8: A rising transition of `cap_clk` while `le` is 1 has no effect beyond pass-through: `y_data` still equals the `a_in` of that edge.
- R9: Storage updates while the outputs are disabled: `y_data` tracks pass-throughs and captures during `oe_n` = 1, and re-enabling drives the updated word on `y_pad`.
- R10: A `cap_clk` level that is high through reset and stays high after reset is released is not a rising transition and captures nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | WIDTH | Input data word |
| le | input | 1 | 1 = pass-through, 0 = load only on a capture strobe rise |
| cap_clk | input | 1 | Capture strobe, sampled as a level |
| oe_n | input | 1 | Active-low output drive enable |
| y_data | output | WIDTH | Stored word, always visible |
| y_oe | output | 1 | Registered drive flag for the output bus |
| y_pad | output | WIDTH | Tri-state copy of the stored word |

## Verification
The input word changes on every step, so pass-through, hold and capture give different results and can be told apart. The strobe is held high across the point where `le` falls, and again held low across it, so that a hold cannot be mistaken for a late capture. A strobe rise is also applied inside pass-through mode, where it must change nothing. The drive enable is dropped while storage is changed in both modes and then raised again, which separates the output gating from the storage itself. A randomised mix of all four inputs runs at the end.

// File: rtl/ubd_pkg.sv
package ubd_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'd0,
    MODE_PASS = 2'd1,
    MODE_CAPT = 2'd2
  } store_mode_t;
endpackage

// File: rtl/ubd_edge_det.sv
module ubd_edge_det (
  input  logic clk,
  input  logic lvl,
  output logic rise
);
  logic prev_q;

  // History register follows the level even in reset, so a strobe held
  // high across reset release is not seen as a rising transition.
  always_ff @(posedge clk) begin
    prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/ubd_mode_sel.sv
module ubd_mode_sel
  import ubd_pkg::*;
(
  input  logic        le,
  input  logic        rise,
  output store_mode_t mode
);
  always_comb begin
    if (le)        mode = MODE_PASS;
    else if (rise) mode = MODE_CAPT;
    else           mode = MODE_HOLD;
  end
endmodule

// File: rtl/ubd_store.sv
module ubd_store
  import ubd_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  store_mode_t      mode,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic load;
  assign load = (mode == MODE_PASS) || (mode == MODE_CAPT);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)       q[i] <= 1'b0;
      else if (load) q[i] <= d[i];
    end
  end
endmodule

// File: rtl/ubd_drive.sv
module ubd_drive #(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             oe_n,
  input  logic [WIDTH-1:0] data,
  output logic             y_oe,
  output logic [WIDTH-1:0] y_pad
);
  always_ff @(posedge clk) begin
    if (rst) y_oe <= 1'b0;
    else     y_oe <= ~oe_n;
  end

  assign y_pad = y_oe ? data : {WIDTH{1'bz}};
endmodule

// File: rtl/lat_reg_driver.sv
module lat_reg_driver
  import ubd_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  input  logic             le,
  input  logic             cap_clk,
  input  logic             oe_n,
  output logic [WIDTH-1:0] y_data,
  output logic             y_oe,
  output logic [WIDTH-1:0] y_pad
);
  logic        strobe_rise;
  store_mode_t mode;

  ubd_edge_det u_edge (
    .clk  (clk),
    .lvl  (cap_clk),
    .rise (strobe_rise)
  );

  ubd_mode_sel u_mode (
    .le   (le),
    .rise (strobe_rise),
    .mode (mode)
  );

  ubd_store #(.WIDTH(WIDTH)) u_store (
    .clk  (clk),
    .rst  (rst),
    .mode (mode),
    .d    (a_in),
    .q    (y_data)
  );

  ubd_drive #(.WIDTH(WIDTH)) u_drive (
    .clk   (clk),
    .rst   (rst),
    .oe_n  (oe_n),
    .data  (y_data),
    .y_oe  (y_oe),
    .y_pad (y_pad)
  );

  assert_pass_R4: assert property (@(posedge clk) disable iff (rst)
    le |=> (y_data == $past(a_in)));

  assert_capture_R5: assert property (@(posedge clk) disable iff (rst)
    (!le && cap_clk && !$past(cap_clk)) |=> (y_data == $past(a_in)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!le && (cap_clk == $past(cap_clk))) |=> $stable(y_data));

  assert_off_R2: assert property (@(posedge clk) disable iff (rst)
    oe_n |=> !y_oe);

  assert_on_R3: assert property (@(posedge clk) disable iff (rst)
    !oe_n |=> y_oe);
endmodule

// File: tb/lat_reg_driver_test.sv
module lat_reg_driver_test;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] a_in;
  logic         le;
  logic         cap_clk;
  logic         oe_n;
  logic [W-1:0] y_data;
  logic         y_oe;
  logic [W-1:0] y_pad;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // reference model state
  logic [W-1:0] m_store;
  logic         m_prev;
  logic         m_oe;

  always #10 clk = ~clk;

  lat_reg_driver #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .a_in(a_in), .le(le),
    .cap_clk(cap_clk), .oe_n(oe_n),
    .y_data(y_data), .y_oe(y_oe), .y_pad(y_pad)
  );

  task automatic check(string tag);
    logic [W-1:0] exp_pad;
    exp_pad = m_oe ? m_store : {W{1'bz}};
    total++;
    if (y_data !== m_store) begin
      bad++;
      $display("FAIL %s y_data actual=%h expected=%h", tag, y_data, m_store);
    end
    total++;
    if (y_oe !== m_oe) begin
      bad++;
      $display("FAIL %s y_oe actual=%b expected=%b", tag, y_oe, m_oe);
    end
    total++;
    if (y_pad !== exp_pad) begin
      bad++;
      $display("FAIL %s y_pad actual=%h expected=%h", tag, y_pad, exp_pad);
    end
  endtask

  // called just after a falling edge: apply inputs, step model, compare at next falling edge
  task automatic cyc(string tag, logic r, logic [W-1:0] a, logic l, logic c, logic o);
    rst = r; a_in = a; le = l; cap_clk = c; oe_n = o;
    if (r) begin
      m_store = '0;
      m_oe    = 1'b0;
    end else begin
      if (l || (c && !m_prev)) m_store = a;
      m_oe = !o;
    end
    m_prev = c;
    @(negedge clk);
    check(tag);
  endtask

  function automatic logic [W-1:0] rnd();
    return W'($urandom);
  endfunction

  initial begin
    m_store = '0; m_prev = 1'b1; m_oe = 1'b0;
    rst = 1'b1; a_in = '0; le = 1'b0; cap_clk = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    // R1: reset with strobe held high
    cyc("R1", 1'b1, rnd(), 1'b0, 1'b1, 1'b1);
    cyc("R1", 1'b1, rnd(), 1'b1, 1'b1, 1'b0);
    cyc("R1", 1'b1, rnd(), 1'b0, 1'b1, 1'b1);
    // R10: strobe still high after release, no capture
    cyc("R10", 1'b0, 18'h2AAAA, 1'b0, 1'b1, 1'b1);
    cyc("R10", 1'b0, 18'h15555, 1'b0, 1'b1, 1'b0);
    // R3 and R4: enabled pass-through follows input
    cyc("R3", 1'b0, 18'h3FFFF, 1'b1, 1'b1, 1'b0);
    cyc("R4", 1'b0, 18'h00001, 1'b1, 1'b1, 1'b0);
    cyc("R4", 1'b0, 18'h20000, 1'b1, 1'b1, 1'b0);
    cyc("R4", 1'b0, 18'h0F0F0, 1'b1, 1'b1, 1'b0);
    // R7: le falls with strobe high, input changes
    cyc("R7", 1'b0, 18'h12345, 1'b0, 1'b1, 1'b0);
    cyc("R6", 1'b0, 18'h3C3C3, 1'b0, 1'b1, 1'b0);
    cyc("R6", 1'b0, 18'h00000, 1'b0, 1'b1, 1'b0);
    // strobe falls then stays low: hold
    cyc("R6", 1'b0, 18'h11111, 1'b0, 1'b0, 1'b0);
    cyc("R6", 1'b0, 18'h22222, 1'b0, 1'b0, 1'b0);
    // R5: rising strobe captures
    cyc("R5", 1'b0, 18'h0ABCD, 1'b0, 1'b1, 1'b0);
    cyc("R6", 1'b0, 18'h3210F, 1'b0, 1'b1, 1'b0);
    cyc("R5", 1'b0, 18'h0AAAA, 1'b0, 1'b0, 1'b0);
    cyc("R5", 1'b0, 18'h35A5A, 1'b0, 1'b1, 1'b0);
    // R8: strobe rise during pass-through
    cyc("R8", 1'b0, 18'h01010, 1'b1, 1'b0, 1'b0);
    cyc("R8", 1'b0, 18'h2F00F, 1'b1, 1'b1, 1'b0);
    cyc("R8", 1'b0, 18'h1EEEE, 1'b1, 1'b1, 1'b0);
    cyc("R8", 1'b0, 18'h0BEEF, 1'b1, 1'b0, 1'b0);
    // R7: le falls with strobe low
    cyc("R7", 1'b0, 18'h30303, 1'b0, 1'b0, 1'b0);
    cyc("R7", 1'b0, 18'h04040, 1'b0, 1'b0, 1'b0);
    // R2 and R9: disabled outputs, storage keeps moving
    cyc("R2", 1'b0, 18'h05050, 1'b0, 1'b0, 1'b1);
    cyc("R9", 1'b0, 18'h16161, 1'b0, 1'b1, 1'b1);
    cyc("R9", 1'b0, 18'h27272, 1'b0, 1'b1, 1'b1);
    cyc("R9", 1'b0, 18'h38383, 1'b1, 1'b0, 1'b1);
    cyc("R9", 1'b0, 18'h09090, 1'b1, 1'b0, 1'b1);
    cyc("R9", 1'b0, 18'h1A1A1, 1'b0, 1'b0, 1'b1);
    cyc("R9", 1'b0, 18'h2B2B2, 1'b0, 1'b0, 1'b0);
    cyc("R3", 1'b0, 18'h3C3C3, 1'b0, 1'b0, 1'b0);
    // reset again mid-run
    cyc("R1", 1'b1, 18'h3FFFF, 1'b1, 1'b0, 1'b0);
    cyc("R1", 1'b0, 18'h3FFFF, 1'b0, 1'b0, 1'b1);
    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      cyc("R5", 1'b0, rnd(), 1'($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom_range(0, 3) == 0));
    end
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule